// File: doc/BRIEF.md
# Serial Result Shifter with Tag Pass-Through

This block is the digital output stage of a sampling converter. A finished conversion delivers a parallel result word on a load port. The block then shifts that word out on one serial data line, MSB first, under a data clock that an external host supplies. Once the last result bit has left, the block does not go idle. It keeps forwarding a serial tag input onto the same line, one bit per clock pulse, so that several devices can share one serial line in a daisy chain. The tag stream continues until the next result is loaded.

The data clock and the tag input are asynchronous to the block's system clock. The block synchronizes both and then detects the data clock's edges. The tag is captured on each rising edge. The serial output advances on each falling edge. The tag enters the shift chain through a one-bit delay register placed behind the LSB, so the delay from tag input to serial output is always the same. The output is only active while chip select is low and the read/convert control is high. A busy flag reports that a fresh result is waiting.

Top module: `ser_tag_shifter`

## Requirements
- R1: `sdata` is 0 whenever `cs_n` is high or `rd_conv` is low.
- R2: After a load, `sdata` shows result bit 15 once the first enabled falling `dclk` edge has passed. It holds that value until the next falling edge, so it is valid at the second rising edge.
- R3: After the k-th enabled falling edge after a load (k = 1..16), `sdata` shows result bit 16-k. The LSB therefore follows the 16th falling edge.
- R4: On each enabled rising `dclk` edge, the level of `tag_in` is captured. The tag captured on rising edge j after a load appears on `sdata` after falling edge 16+j.
- R5: Under a continuous clock, tag bits keep appearing on `sdata` for any number of pulses until the next load (checked with 40 tag bits).
- R6: In the cycle after `ld_valid` is high, `busy` is 1, and it stays 1 until a convert command.
- R7: A convert command (`cs_n` low and `rd_conv` low) clears `busy`, unless `ld_valid` is high in the same cycle, in which case `busy` ends at 1.
- R8: A load restarts the sequence. `sdata` is 0 until the first falling edge after the load, and the next falling edges start again at the new MSB. A tag bit captured before the load never reaches `sdata`; the position it held in the chain reads 0.
- R9: `dclk` edges that occur while the output is disabled neither advance the result nor capture a tag. The sequence resumes where it stopped once the output is enabled again.
- R10: After reset, `sdata` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | High = read, low together with cs_n low = convert command |
| dclk | input | 1 | Asynchronous external data clock |
| tag_in | input | 1 | Serial tag input, asynchronous |
| ld_valid | input | 1 | One-cycle strobe that loads a new result |
| ld_data | input | RES_W | Result word to load |
| sdata | output | 1 | Serial data output |
| busy | output | 1 | High once a new result has been loaded |

## Verification
The hardest case to reach is a reload that lands between a rising and a falling data-clock edge, while a tag bit is already sitting in the delay register. The bench raises `dclk` with the tag high, strobes a load while `dclk` is still high, and only then lowers it. It then checks that the first post-load falling edge gives the new MSB and that the slot after the LSB reads 0 rather than the stale tag. A second hard case is a stream interrupted by `dclk` pulses that arrive while chip select is high. The bench drives such pulses with the tag held at 1 and checks that the sequence resumes exactly where it stopped.

// File: rtl/ser_tag_pkg.sv
package ser_tag_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
    logic tag;
  } dclk_evt_t;
endpackage

// File: rtl/ser_tag_edge.sv
module ser_tag_edge
  import ser_tag_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      dclk,
  input  logic      tag_in,
  output dclk_evt_t evt
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] dsync;
  logic [SYNC_STAGES-1:0] tsync;
  logic                   dprev;

  always_ff @(posedge clk) begin
    if (rst) begin
      dsync <= '0;
      tsync <= '0;
      dprev <= 1'b0;
    end else begin
      dsync[0] <= dclk;
      tsync[0] <= tag_in;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        dsync[i] <= dsync[i-1];
        tsync[i] <= tsync[i-1];
      end
      dprev <= dsync[LAST];
    end
  end

  assign evt.rise = dsync[LAST] & ~dprev;
  assign evt.fall = ~dsync[LAST] & dprev;
  assign evt.tag  = tsync[LAST];
endmodule

// File: rtl/ser_tag_chain.sv
module ser_tag_chain
  import ser_tag_pkg::*;
#(
  parameter int unsigned RES_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  dclk_evt_t        evt,
  input  logic             en,
  input  logic             ld,
  input  logic [RES_W-1:0] ld_data,
  output logic             cur_bit
);
  logic [RES_W-1:0] sh_q;
  logic             tag_q;
  logic             cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      tag_q <= 1'b0;
      cur_q <= 1'b0;
    end else if (ld) begin
      sh_q  <= ld_data;
      tag_q <= 1'b0;
      cur_q <= 1'b0;
    end else if (en) begin
      if (evt.rise) tag_q <= evt.tag;
      if (evt.fall) begin
        cur_q <= sh_q[RES_W-1];
        sh_q  <= {sh_q[RES_W-2:0], tag_q};
      end
    end
  end

  assign cur_bit = cur_q;

  AST_RELOAD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ld |=> (!cur_q && !tag_q)); // R8
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && !ld) |=> ($stable(sh_q) && $stable(tag_q) && $stable(cur_q))); // R9
endmodule

// File: rtl/ser_tag_busy.sv
module ser_tag_busy (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  input  logic cs_n,
  input  logic rd_conv,
  output logic busy
);
  logic busy_q;
  logic conv_cmd;

  assign conv_cmd = ~cs_n & ~rd_conv;

  always_ff @(posedge clk) begin
    if (rst)           busy_q <= 1'b0;
    else if (ld)       busy_q <= 1'b1;
    else if (conv_cmd) busy_q <= 1'b0;
  end

  assign busy = busy_q;

  AST_BUSY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld |=> busy_q); // R6
  AST_BUSY_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(!cs_n && !rd_conv && !ld)); // R7
endmodule

// File: rtl/ser_tag_shifter.sv
module ser_tag_shifter
  import ser_tag_pkg::*;
#(
  parameter int unsigned RES_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_conv,
  input  logic             dclk,
  input  logic             tag_in,
  input  logic             ld_valid,
  input  logic [RES_W-1:0] ld_data,
  output logic             sdata,
  output logic             busy
);
  dclk_evt_t evt;
  logic      out_en;
  logic      cur_bit;
  logic      sdata_q;

  assign out_en = ~cs_n & rd_conv;

  ser_tag_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .dclk   (dclk),
    .tag_in (tag_in),
    .evt    (evt)
  );

  ser_tag_chain #(.RES_W(RES_W)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .en      (out_en),
    .ld      (ld_valid),
    .ld_data (ld_data),
    .cur_bit (cur_bit)
  );

  ser_tag_busy u_busy (
    .clk     (clk),
    .rst     (rst),
    .ld      (ld_valid),
    .cs_n    (cs_n),
    .rd_conv (rd_conv),
    .busy    (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) sdata_q <= 1'b0;
    else     sdata_q <= out_en & cur_bit;
  end

  assign sdata = sdata_q;

  AST_SDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(!cs_n && rd_conv) |=> !sdata); // R1
endmodule

// File: tb/ser_tag_shifter_tb.sv
module ser_tag_shifter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b0;
  logic        rd_conv = 1'b1;
  logic        dclk = 1'b0;
  logic        tag_in = 1'b0;
  logic        ld_valid = 1'b0;
  logic [15:0] ld_data = '0;
  logic        sdata;
  logic        busy;

  int checks = 0;
  int errors = 0;
  logic tg [0:63];

  always #2.5 clk = ~clk;

  ser_tag_shifter u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_conv(rd_conv), .dclk(dclk),
    .tag_in(tag_in), .ld_valid(ld_valid), .ld_data(ld_data),
    .sdata(sdata), .busy(busy)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load(input logic [15:0] w);
    @(negedge clk); ld_data = w; ld_valid = 1'b1;
    @(negedge clk); ld_valid = 1'b0;
  endtask

  task automatic pulse(input logic t);
    tag_in = t;
    repeat (4) @(negedge clk);
    dclk = 1'b1;
    repeat (8) @(negedge clk);
    dclk = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic tag_of(input int seed, input int j);
    return ((j * 5 + seed) % 7) < 3;
  endfunction

  function automatic logic [15:0] word_of(input int k);
    case (k)
      0: return 16'hA5C3;
      1: return 16'h8000;
      2: return 16'h0001;
      3: return 16'hFFFF;
      4: return 16'h0000;
      default: return 16'((k * 40503) ^ (4660 << k));
    endcase
  endfunction

  function automatic string req_of(input int j);
    if (j == 1) return "R2";
    if (j <= 16) return "R3";
    if (j <= 32) return "R4";
    return "R5";
  endfunction

  function automatic logic exp_of(input logic [15:0] w, input int j);
    if (j <= 16) return w[16-j];
    return tg[j-16];
  endfunction

  task automatic run_word(input logic [15:0] w, input int seed, input int ntag);
    load(w);
    repeat (6) @(negedge clk);
    check(sdata, 1'b0, "R8");
    check(busy, 1'b1, "R6");
    for (int j = 1; j <= 16 + ntag; j++) begin
      tg[j] = tag_of(seed, j);
      pulse(tg[j]);
      check(sdata, exp_of(w, j), req_of(j));
    end
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    int j;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(sdata, 1'b0, "R10");
    check(busy, 1'b0, "R10");

    // R2 R3 R4 over several words; R5 with a long tag run
    for (int k = 0; k < 8; k++) run_word(word_of(k), k, (k == 3) ? 40 : 24);

    // R9: pulses while disabled are ignored
    w = 16'hC35A;
    load(w);
    j = 0;
    for (int p = 0; p < 5; p++) begin
      j++; tg[j] = tag_of(9, j); pulse(tg[j]);
      check(sdata, exp_of(w, j), "R3");
    end
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check(sdata, 1'b0, "R1");
    for (int p = 0; p < 3; p++) begin
      pulse(1'b1);
      check(sdata, 1'b0, "R1");
    end
    cs_n = 1'b0; rd_conv = 1'b1;
    repeat (6) @(negedge clk);
    check(sdata, w[11], "R9");
    while (j < 28) begin
      j++; tg[j] = tag_of(9, j); pulse(tg[j]);
      check(sdata, exp_of(w, j), "R9");
    end
    cs_n = 1'b1; rd_conv = 1'b0;
    repeat (6) @(negedge clk);
    check(sdata, 1'b0, "R1");
    check(busy, 1'b1, "R7");
    cs_n = 1'b1; rd_conv = 1'b1;

    // R8: reload between a rising and a falling edge with tag high
    load(16'h1234);
    for (int p = 0; p < 7; p++) pulse(1'b1);
    w = 16'hB6E9;
    tag_in = 1'b1;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    dclk = 1'b1;
    repeat (8) @(negedge clk);
    load(w);
    repeat (4) @(negedge clk);
    check(sdata, 1'b0, "R8");
    dclk = 1'b0;
    repeat (8) @(negedge clk);
    check(sdata, w[15], "R8");
    tg[1] = 1'b0;
    for (int q = 2; q <= 24; q++) begin
      tg[q] = q[0];
      pulse(tg[q]);
      check(sdata, exp_of(w, q), "R8");
    end

    // R6 / R7: busy behaviour
    check(busy, 1'b1, "R6");
    @(negedge clk); cs_n = 1'b0; rd_conv = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1; rd_conv = 1'b1;
    @(negedge clk);
    check(busy, 1'b0, "R7");
    check(sdata, 1'b0, "R1");
    load(16'h0F0F);
    check(busy, 1'b1, "R6");
    @(negedge clk); cs_n = 1'b0; rd_conv = 1'b0;
    @(negedge clk); cs_n = 1'b0; rd_conv = 1'b0; ld_valid = 1'b1; ld_data = 16'h5555;
    @(negedge clk); ld_valid = 1'b0; cs_n = 1'b1; rd_conv = 1'b1;
    @(negedge clk);
    check(busy, 1'b1, "R7");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule